// File: doc/BRIEF.md
# Clock Synthesiser Divider Code Calculator

This block turns a measured reference clock frequency into the two divider codes a clock synthesiser needs. The synthesiser multiplies its input by (F+2)/(R+2), with the post divider fixed at one. The target output is 133,333,333 Hz when the fast device class is selected and 100,000,000 Hz otherwise. A pulse on `start` captures the reference frequency and the class. The block first rejects an implausible reference. It then derives a multiplication factor scaled by 1000 and picks R from a fixed set of ratio bands. Last, it computes F and checks that it fits in seven bits.

All three divisions share one multi-cycle restoring divider. The block raises `busy` while a calculation is under way. It ends each run with a one-cycle `done` pulse and holds either `ok` with the two codes, or `err` with both codes at zero, until the next accepted start.

Top module: `pll_divcalc`

## Requirements
- R1: The target frequency is 133,333,333 Hz when `fast_class` is 1 at the accepted start and 100,000,000 Hz when it is 0.
- R2: A reference below 5,000,000 Hz or above 70,000,000 Hz ends the run with `err`=1 and `done`=1 in the first cycle after the start, and `busy` never rises.
- R3: The scaled ratio is target / (reference / 1000), with both quotients truncated. A ratio of 64000 or more ends the run with `err`.
- R4: `ctl1` (R) is 13 for a ratio below 8600, else 8 below 12900, else 6 below 16100, else 0 below 64000. A ratio of exactly 8600 gives 8.
- R5: F = ratio*(R+2)/1000 - 2 with truncation. A value outside 0..127 ends the run with `err`.
- R6: After a valid run `ok`=1, `ctl0`=F and `ctl1`=R, held until the next accepted start. After an error `err`=1 and both codes read 0. `ok` and `err` are never both high.
- R7: `busy` is high from the cycle after an accepted in-range start until the run finishes. `done` lasts exactly one cycle and is low while `busy` is high. A `start` while `busy` is high is ignored.
- R8: A `start` in the same cycle as `done` is accepted. In the next cycle `ok` and `err` are both 0 and the new run's result follows.
- R9: After reset `busy`, `done`, `ok` and `err` are 0 and both codes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a calculation (taken when not busy) |
| fast_class | input | 1 | Selects the 133.33 MHz target when 1 |
| ref_hz | input | W | Measured reference frequency in Hz |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| ok | output | 1 | Last run produced valid codes |
| err | output | 1 | Last run was rejected |
| ctl0 | output | CW | Feedback divider code F |
| ctl1 | output | CW | Reference divider code R |

## Verification
The end-of-run pulse and the acceptance of a new start can fall in the same cycle. The bench waits for `done`, raises `start` with a different reference in that very cycle, and expects the old result on the ports during that cycle. One cycle later it expects `busy` high with `ok` and `err` both cleared, and after the next `done` it expects the codes of the second request. A start pulsed mid-run is judged by the first request's codes appearing unchanged at the end. A second instance with widened input limits is used to reach the ratio and F error paths that the default limits never reach.

// File: rtl/pll_divcalc_pkg.sv
package pll_divcalc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_KHZ   = 2'd1,
    ST_RATIO = 2'd2,
    ST_FB    = 2'd3
  } calc_st_t;

  // Ratio bands, ascending upper limits (exclusive) and the R code for each.
  localparam int NUM_BANDS = 4;
  localparam int unsigned BAND_LIM  [NUM_BANDS] = '{8600, 12900, 16100, 64000};
  localparam int unsigned BAND_CODE [NUM_BANDS] = '{13, 8, 6, 0};

endpackage

// File: rtl/pll_rdiv.sv
module pll_rdiv #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         done,
  output logic [W-1:0] quo
);
  localparam int CNT_W = $clog2(W + 1);

  logic [W-1:0]     rem_q;
  logic [W-1:0]     den_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic [W:0]       shifted;
  logic             take;

  assign shifted = {rem_q, quo[W-1]};
  assign take    = shifted >= {1'b0, den_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      den_q <= '0;
      quo   <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        rem_q <= '0;
        den_q <= den;
        quo   <= num;
        cnt_q <= CNT_W'(W);
        run_q <= 1'b1;
      end else if (run_q) begin
        if (take) begin
          rem_q <= W'(shifted - {1'b0, den_q});
          quo   <= {quo[W-2:0], 1'b1};
        end else begin
          rem_q <= shifted[W-1:0];
          quo   <= {quo[W-2:0], 1'b0};
        end
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          run_q <= 1'b0;
          done  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pll_band_sel.sv
module pll_band_sel
  import pll_divcalc_pkg::*;
#(
  parameter int W  = 32,
  parameter int CW = 8
) (
  input  logic [W-1:0]  ratio,
  output logic [CW-1:0] r_code,
  output logic          over
);
  logic [NUM_BANDS-1:0] below;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_BANDS; gi++) begin : g_cmp
      assign below[gi] = ratio < W'(BAND_LIM[gi]);
    end
  endgenerate

  // The lowest band whose limit exceeds the ratio wins.
  always_comb begin
    r_code = '0;
    for (int i = NUM_BANDS - 1; i >= 0; i--) begin
      if (below[i]) r_code = CW'(BAND_CODE[i]);
    end
  end

  assign over = !below[NUM_BANDS-1];
endmodule

// File: rtl/pll_divcalc.sv
module pll_divcalc
  import pll_divcalc_pkg::*;
#(
  parameter int          W       = 32,
  parameter int          CW      = 8,
  parameter int unsigned LO_HZ   = 5_000_000,
  parameter int unsigned HI_HZ   = 70_000_000,
  parameter int unsigned FAST_HZ = 133_333_333,
  parameter int unsigned SLOW_HZ = 100_000_000,
  parameter int unsigned SCALE   = 1000,
  parameter int unsigned F_OFS   = 2,
  parameter int unsigned F_MAX   = 127
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          fast_class,
  input  logic [W-1:0]  ref_hz,
  output logic          busy,
  output logic          done,
  output logic          ok,
  output logic          err,
  output logic [CW-1:0] ctl0,
  output logic [CW-1:0] ctl1
);
  localparam logic [W-1:0] F_HI = W'(F_MAX + F_OFS);

  calc_st_t      st;
  logic [W-1:0]  tgt_q;
  logic [CW-1:0] r_sel_q;
  logic          div_go;
  logic [W-1:0]  div_num;
  logic [W-1:0]  div_den;
  logic          div_done;
  logic [W-1:0]  div_q;
  logic [CW-1:0] band_r;
  logic          band_over;
  logic [W-1:0]  r_plus;
  logic [W-1:0]  prod;
  logic          in_range;

  pll_rdiv #(.W(W)) u_div (
    .clk  (clk),
    .rst  (rst),
    .go   (div_go),
    .num  (div_num),
    .den  (div_den),
    .done (div_done),
    .quo  (div_q)
  );

  pll_band_sel #(.W(W), .CW(CW)) u_band (
    .ratio  (div_q),
    .r_code (band_r),
    .over   (band_over)
  );

  assign r_plus   = W'(band_r) + W'(F_OFS);
  assign prod     = div_q * r_plus;
  assign in_range = (ref_hz >= W'(LO_HZ)) && (ref_hz <= W'(HI_HZ));

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      tgt_q   <= '0;
      r_sel_q <= '0;
      div_go  <= 1'b0;
      div_num <= '0;
      div_den <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      ok      <= 1'b0;
      err     <= 1'b0;
      ctl0    <= '0;
      ctl1    <= '0;
    end else begin
      div_go <= 1'b0;
      done   <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            ok    <= 1'b0;
            err   <= 1'b0;
            ctl0  <= '0;
            ctl1  <= '0;
            tgt_q <= fast_class ? W'(FAST_HZ) : W'(SLOW_HZ);
            if (!in_range) begin
              err  <= 1'b1;
              done <= 1'b1;
            end else begin
              div_num <= ref_hz;
              div_den <= W'(SCALE);
              div_go  <= 1'b1;
              busy    <= 1'b1;
              st      <= ST_KHZ;
            end
          end
        end
        ST_KHZ: begin
          if (div_done) begin
            div_num <= tgt_q;
            div_den <= div_q;
            div_go  <= 1'b1;
            st      <= ST_RATIO;
          end
        end
        ST_RATIO: begin
          if (div_done) begin
            if (band_over) begin
              err  <= 1'b1;
              done <= 1'b1;
              busy <= 1'b0;
              st   <= ST_IDLE;
            end else begin
              r_sel_q <= band_r;
              div_num <= prod;
              div_den <= W'(SCALE);
              div_go  <= 1'b1;
              st      <= ST_FB;
            end
          end
        end
        ST_FB: begin
          if (div_done) begin
            if (div_q < W'(F_OFS) || div_q > F_HI) begin
              err <= 1'b1;
            end else begin
              ok   <= 1'b1;
              ctl0 <= CW'(div_q - W'(F_OFS));
              ctl1 <= r_sel_q;
            end
            done <= 1'b1;
            busy <= 1'b0;
            st   <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pll_divcalc_chk.sv
module pll_divcalc_chk
  import pll_divcalc_pkg::*;
#(
  parameter int          W     = 32,
  parameter int          CW    = 8,
  parameter int unsigned LO_HZ = 5_000_000,
  parameter int unsigned HI_HZ = 70_000_000
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [W-1:0]  ref_hz,
  input logic          busy,
  input logic          done,
  input logic          ok,
  input logic          err,
  input logic [CW-1:0] ctl0,
  input logic [CW-1:0] ctl1
);
  logic bad_ref;
  assign bad_ref = (ref_hz < W'(LO_HZ)) || (ref_hz > W'(HI_HZ));

  assert_range_reject_R2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && bad_ref) |=> (done && err && !busy));

  assert_r_code_set_R4: assert property (@(posedge clk) disable iff (rst)
    ok |-> (ctl1 == CW'(BAND_CODE[0]) || ctl1 == CW'(BAND_CODE[1]) ||
            ctl1 == CW'(BAND_CODE[2]) || ctl1 == CW'(BAND_CODE[3])));

  assert_f_fits_R5: assert property (@(posedge clk) disable iff (rst)
    ok |-> (ctl0 <= CW'(127)));

  assert_ok_err_excl_R6: assert property (@(posedge clk) disable iff (rst)
    !(ok && err));

  assert_codes_zero_R6: assert property (@(posedge clk) disable iff (rst)
    !ok |-> (ctl0 == '0 && ctl1 == '0));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_busy_no_done_R7: assert property (@(posedge clk) disable iff (rst)
    busy |-> !done);

  assert_start_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && !bad_ref) |=> (busy && !ok && !err));
endmodule

bind pll_divcalc pll_divcalc_chk #(
  .W(W), .CW(CW), .LO_HZ(LO_HZ), .HI_HZ(HI_HZ)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .ref_hz (ref_hz),
  .busy   (busy),
  .done   (done),
  .ok     (ok),
  .err    (err),
  .ctl0   (ctl0),
  .ctl1   (ctl1)
);

// File: tb/pll_divcalc_bench.sv
`timescale 1ns/1ps
module pll_divcalc_bench;
  localparam int LIMIT = 400;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_n = 1'b0;
  logic start_w = 1'b0;
  logic fast = 1'b0;
  logic [31:0] ref_hz = '0;

  logic busy_n, done_n, ok_n, err_n;
  logic [7:0] c0_n, c1_n;
  logic busy_w, done_w, ok_w, err_w;
  logic [7:0] c0_w, c1_w;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pll_divcalc u_pll_divcalc (
    .clk(clk), .rst(rst), .start(start_n), .fast_class(fast), .ref_hz(ref_hz),
    .busy(busy_n), .done(done_n), .ok(ok_n), .err(err_n), .ctl0(c0_n), .ctl1(c1_n)
  );

  pll_divcalc #(.LO_HZ(1_000_000), .HI_HZ(2_000_000_000)) u_pll_divcalc_wide (
    .clk(clk), .rst(rst), .start(start_w), .fast_class(fast), .ref_hz(ref_hz),
    .busy(busy_w), .done(done_w), .ok(ok_w), .err(err_w), .ctl0(c0_w), .ctl1(c1_w)
  );

  typedef struct packed {
    logic       fast;
    logic [31:0] hz;
    logic       exp_err;
    logic [7:0] exp_f;
    logic [7:0] exp_r;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 32'd33_333_333, 1'b0, 8'd58,  8'd13},
    '{1'b0, 32'd33_333_333, 1'b0, 8'd43,  8'd13},
    '{1'b1, 32'd16_949_000, 1'b0, 8'd115, 8'd13},
    '{1'b1, 32'd10_000_000, 1'b0, 8'd104, 8'd6},
    '{1'b0, 32'd10_000_000, 1'b0, 8'd98,  8'd8},
    '{1'b1, 32'd5_000_000,  1'b0, 8'd51,  8'd0},
    '{1'b0, 32'd5_000_000,  1'b0, 8'd38,  8'd0},
    '{1'b1, 32'd70_000_000, 1'b0, 8'd26,  8'd13},
    '{1'b0, 32'd70_000_000, 1'b0, 8'd19,  8'd13},
    '{1'b1, 32'd15_503_000, 1'b0, 8'd84,  8'd8},
    '{1'b1, 32'd15_504_000, 1'b0, 8'd126, 8'd13},
    '{1'b0, 32'd4_999_999,  1'b1, 8'd0,   8'd0},
    '{1'b1, 32'd70_000_001, 1'b1, 8'd0,   8'd0}
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Wait, at falling edges, for the selected instance's done pulse.
  task automatic wait_done(input bit wide, output int waited);
    waited = 0;
    while (!(wide ? done_w : done_n) && waited < LIMIT) begin
      @(negedge clk);
      waited++;
    end
    if (waited >= LIMIT) check("watchdog R7", 0, 1);
  endtask

  task automatic launch(input bit wide, input bit f, input logic [31:0] hz);
    @(negedge clk);
    fast = f;
    ref_hz = hz;
    if (wide) start_w = 1'b1; else start_n = 1'b1;
    @(negedge clk);
    start_n = 1'b0;
    start_w = 1'b0;
  endtask

  task automatic expect_result(input bit wide, input string tag, input bit e_err,
                               input int e_f, input int e_r);
    check({tag, " err"}, wide ? err_w : err_n, e_err);
    check({tag, " ok"},  wide ? ok_w  : ok_n,  !e_err);
    check({tag, " ctl0"}, wide ? c0_w : c0_n, e_f);
    check({tag, " ctl1"}, wide ? c1_w : c1_n, e_r);
  endtask

  initial begin
    #(5.0 * 150000);
    check("global watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int w;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    check("R9 busy", busy_n, 0);
    check("R9 done", done_n, 0);
    check("R9 ok", ok_n, 0);
    check("R9 err", err_n, 0);
    check("R9 ctl0", c0_n, 0);
    check("R9 ctl1", c1_n, 0);

    // Table walk: R1 target per class, R3 ratio, R4 bands, R5 F, R6 result hold
    for (int i = 0; i < NV; i++) begin
      launch(1'b0, VECS[i].fast, VECS[i].hz);
      wait_done(1'b0, w);
      expect_result(1'b0, $sformatf("R1/R4/R5/R6 vec%0d", i), VECS[i].exp_err,
                    VECS[i].exp_f, VECS[i].exp_r);
      if (VECS[i].exp_err) begin
        check($sformatf("R2 immediate vec%0d", i), w, 0);
        check($sformatf("R2 no busy vec%0d", i), busy_n, 0);
      end
      @(negedge clk);
      check($sformatf("R7 done one cycle vec%0d", i), done_n, 0);
      check($sformatf("R6 held vec%0d", i), VECS[i].exp_err ? err_n : ok_n, 1);
    end

    // R7: busy during a run, start while busy ignored
    launch(1'b0, 1'b1, 32'd33_333_333);
    check("R7 busy after start", busy_n, 1);
    repeat (10) @(negedge clk);
    fast = 1'b0;
    ref_hz = 32'd10_000_000;
    start_n = 1'b1;
    @(negedge clk);
    start_n = 1'b0;
    wait_done(1'b0, w);
    expect_result(1'b0, "R7 ignored start", 1'b0, 58, 13);

    // R8: start in the same cycle as done
    fast = 1'b0;
    ref_hz = 32'd10_000_000;
    start_n = 1'b1;
    check("R8 old result in done cycle", ok_n, 1);
    @(negedge clk);
    start_n = 1'b0;
    check("R8 busy", busy_n, 1);
    check("R8 ok cleared", ok_n, 0);
    check("R8 err cleared", err_n, 0);
    check("R8 done low", done_n, 0);
    wait_done(1'b0, w);
    expect_result(1'b0, "R8 second run", 1'b0, 98, 8);

    // R3: ratio of 64000 or more rejected (widened limits instance)
    launch(1'b1, 1'b1, 32'd2_000_000);
    wait_done(1'b1, w);
    expect_result(1'b1, "R3 ratio over", 1'b1, 0, 0);

    // R5: F below zero rejected
    launch(1'b1, 1'b1, 32'd1_000_000_000);
    wait_done(1'b1, w);
    expect_result(1'b1, "R5 F negative", 1'b1, 0, 0);

    // R6: valid run after an error clears err
    launch(1'b1, 1'b1, 32'd10_000_000);
    wait_done(1'b1, w);
    expect_result(1'b1, "R6 recover", 1'b0, 104, 6);

    finish_run();
  end
endmodule